// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block collects two interrupt sources for a small CPU: one dedicated external interrupt pin, and a group of general I/O pins watched for any transition. Every pin passes through a two-flop synchronizer. The external pin is then classified by a two-bit sense setting as low level, any change, falling edge or rising edge. The pin group raises one shared event whenever any of its bits toggles. The block looks only at the pin values and has no direction input, so a pin driven by the chip itself triggers exactly as an input would.

Software reaches two byte-wide registers on a simple register bus. The enable register holds one enable bit per source. The pending register holds one latched flag per source; writing a one to a flag clears it. A request goes to the CPU sequencer only when a source is pending, its enable bit is set and the global interrupt enable input is high. The sequencer receives a request line and a vector address. When it pulses the taken input, the flag behind the presented vector is cleared.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The enable register at bus address 0x3B holds the external enable in bit 6 and the pin-change enable in bit 5. Both bits can be written and read back, and both are 0 after reset.
- R2: The pending register at bus address 0x3A shows the external flag in bit 6 and the pin-change flag in bit 5. Both are 0 after reset.
- R3: Every bit other than 6 and 5 of both registers reads as 0 whatever was written, and any other bus address reads 0.
- R4: With sense 2'b10, a high-to-low transition of the external pin sets the external flag and a low-to-high transition does not. With sense 2'b11, the reverse holds. The flag is visible three clock edges after the pin changes.
- R5: With sense 2'b01, both transitions of the external pin set the external flag.
- R6: With sense 2'b00, the external source is pending for as long as the synchronized pin is low, and no flag is latched. The request drops once the pin returns high.
- R7: A transition on any bit of the watched pin group sets the pin-change flag, and the flag stays set while further pins toggle. No pin direction is consulted.
- R8: A flag is set even while its enable bit is 0. irq_req is high only when an enabled source is pending and gie is 1.
- R9: irq_vec shows 0x001 for the external source and 0x002 for the pin-change source. The external source wins when both are active, and irq_vec is 0 while irq_req is low.
- R10: Writing a one to a flag bit of the pending register clears that flag. Writing a zero leaves it unchanged.
- R11: A vec_taken pulse while irq_req is high clears only the flag of the vector being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sense_mode | input | 2 | External sense: 00 low, 01 any change, 10 falling, 11 rising |
| gie | input | 1 | Global interrupt enable from the CPU |
| xint_pin | input | 1 | External interrupt pin, asynchronous |
| watch_pins | input | 5 | Pin group watched for change, asynchronous |
| vec_taken | input | 1 | Sequencer pulse: presented vector accepted |
| irq_req | output | 1 | Interrupt request to the sequencer |
| irq_vec | output | 9 | Vector address of the winning source |

## Verification
The hardest case to reach from the ports is two sources pending together and then being retired one at a time. The vector must hand over from 0x001 to 0x002, and the first vec_taken pulse must leave the pin-change flag untouched. The bench holds gie low while it moves the external pin and the pin group in the same cycle. It waits for both flags to settle through the synchronizers and only then raises gie. This way the first request the sequencer sees already has both sources competing. Level sensing is reached separately: the pin is held low with sense 00, and the bench checks that the pending register stays empty while the request is up.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Bit positions inside both software registers.
  localparam int EXT_BIT = 6;
  localparam int PC_BIT  = 5;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    meta_d = d;
    hold_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign q = hold_q;

endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense
  import irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_t mode,
  output logic   edge_evt,
  output logic   level_act
);

  logic prev_q, prev_d;
  logic rise, fall;

  always_comb prev_d = pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  always_comb begin
    rise      = pin_s & ~prev_q;
    fall      = ~pin_s & prev_q;
    edge_evt  = 1'b0;
    level_act = 1'b0;
    unique case (mode)
      SENSE_LOW:  level_act = ~pin_s;
      SENSE_ANY:  edge_evt  = rise | fall;
      SENSE_FALL: edge_evt  = fall;
      SENSE_RISE: edge_evt  = rise;
      default:    edge_evt  = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_pc_detect.sv
module irq_pc_detect #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_s,
  output logic         chg_evt
);

  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] diff;

  always_comb prev_d = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    diff    = pins_s ^ prev_q;
    chg_evt = |diff;
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int            AW        = 6,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] MASK_ADDR = 6'h3B,
  parameter logic [AW-1:0] FLAG_ADDR = 6'h3A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          set_ext,
  input  logic          set_pc,
  input  logic          take_ext,
  input  logic          take_pc,
  output logic          en_ext,
  output logic          en_pc,
  output logic          flag_ext,
  output logic          flag_pc,
  output logic [DW-1:0] bus_rdata
);

  logic en_ext_q, en_ext_d, en_pc_q, en_pc_d;
  logic fl_ext_q, fl_ext_d, fl_pc_q, fl_pc_d;
  logic mask_wr, flag_wr, clr_ext, clr_pc;

  always_comb begin
    mask_wr = bus_we && (bus_addr == MASK_ADDR);
    flag_wr = bus_we && (bus_addr == FLAG_ADDR);
    clr_ext = (flag_wr && bus_wdata[EXT_BIT]) || take_ext;
    clr_pc  = (flag_wr && bus_wdata[PC_BIT])  || take_pc;

    en_ext_d = mask_wr ? bus_wdata[EXT_BIT] : en_ext_q;
    en_pc_d  = mask_wr ? bus_wdata[PC_BIT]  : en_pc_q;

    // A fresh event outranks a clear in the same cycle.
    fl_ext_d = fl_ext_q;
    if (clr_ext) fl_ext_d = 1'b0;
    if (set_ext) fl_ext_d = 1'b1;
    fl_pc_d = fl_pc_q;
    if (clr_pc) fl_pc_d = 1'b0;
    if (set_pc) fl_pc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ext_q <= 1'b0;
      en_pc_q  <= 1'b0;
      fl_ext_q <= 1'b0;
      fl_pc_q  <= 1'b0;
    end else begin
      en_ext_q <= en_ext_d;
      en_pc_q  <= en_pc_d;
      fl_ext_q <= fl_ext_d;
      fl_pc_q  <= fl_pc_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == MASK_ADDR) begin
      bus_rdata[EXT_BIT] = en_ext_q;
      bus_rdata[PC_BIT]  = en_pc_q;
    end else if (bus_addr == FLAG_ADDR) begin
      bus_rdata[EXT_BIT] = fl_ext_q;
      bus_rdata[PC_BIT]  = fl_pc_q;
    end
  end

  assign en_ext   = en_ext_q;
  assign en_pc    = en_pc_q;
  assign flag_ext = fl_ext_q;
  assign flag_pc  = fl_pc_q;

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_pkg::*;
#(
  parameter int               NPINS     = 5,
  parameter int               AW        = 6,
  parameter int               DW        = 8,
  parameter int               VEC_W     = 9,
  parameter logic [AW-1:0]    MASK_ADDR = 6'h3B,
  parameter logic [AW-1:0]    FLAG_ADDR = 6'h3A,
  parameter logic [VEC_W-1:0] EXT_VEC   = 9'h001,
  parameter logic [VEC_W-1:0] PC_VEC    = 9'h002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_we,
  output logic [DW-1:0]    bus_rdata,
  input  logic [1:0]       sense_mode,
  input  logic             gie,
  input  logic             xint_pin,
  input  logic [NPINS-1:0] watch_pins,
  input  logic             vec_taken,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             xint_s;
  logic [NPINS-1:0] pins_s;
  logic             ext_evt, ext_level, pc_evt;
  logic             en_ext, en_pc, flag_ext, flag_pc;
  logic             ext_act, pc_act, take_ext, take_pc;
  sense_t           mode;

  assign mode = sense_t'(sense_mode);

  irq_sync #(.W(1), .RST_VAL(1'b1)) u_xsync (
    .clk(clk), .rst_n(rst_sync_q), .d(xint_pin), .q(xint_s)
  );

  irq_sync #(.W(NPINS), .RST_VAL('0)) u_psync (
    .clk(clk), .rst_n(rst_sync_q), .d(watch_pins), .q(pins_s)
  );

  irq_ext_sense u_sense (
    .clk(clk), .rst_n(rst_sync_q), .pin_s(xint_s), .mode(mode),
    .edge_evt(ext_evt), .level_act(ext_level)
  );

  irq_pc_detect #(.W(NPINS)) u_pcdet (
    .clk(clk), .rst_n(rst_sync_q), .pins_s(pins_s), .chg_evt(pc_evt)
  );

  irq_regs #(
    .AW(AW), .DW(DW), .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_q),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .set_ext(ext_evt), .set_pc(pc_evt),
    .take_ext(take_ext), .take_pc(take_pc),
    .en_ext(en_ext), .en_pc(en_pc),
    .flag_ext(flag_ext), .flag_pc(flag_pc),
    .bus_rdata(bus_rdata)
  );

  // Fixed priority: the lower vector address wins.
  always_comb begin
    ext_act  = gie && en_ext && (flag_ext || ext_level);
    pc_act   = gie && en_pc && flag_pc;
    irq_req  = ext_act || pc_act;
    irq_vec  = ext_act ? EXT_VEC : (pc_act ? PC_VEC : '0);
    take_ext = vec_taken && ext_act;
    take_pc  = vec_taken && pc_act && !ext_act;
  end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int               AW        = 6,
  parameter int               DW        = 8,
  parameter int               VEC_W     = 9,
  parameter logic [AW-1:0]    FLAG_ADDR = 6'h3A,
  parameter logic [VEC_W-1:0] EXT_VEC   = 9'h001
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [DW-1:0]    bus_rdata,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             bus_we,
  input logic             vec_taken,
  input logic             flag_ext,
  input logic             flag_pc,
  input logic             en_ext,
  input logic             ext_evt,
  input logic             ext_level,
  input logic             pc_evt
);

  localparam logic [DW-1:0] LIVE = (DW'(1) << EXT_BIT) | (DW'(1) << PC_BIT);

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE) == '0);

  p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);

  p_idle_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0);

  p_level_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && en_ext && ext_level) |-> (irq_req && irq_vec == EXT_VEC));

  p_pc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_evt |=> flag_pc);

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == FLAG_ADDR && bus_wdata[PC_BIT] && !pc_evt) |=> !flag_pc);

  p_take_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_taken && irq_req && irq_vec == EXT_VEC && !ext_evt && !(flag_pc && pc_evt == 1'b0 && 1'b0))
      |=> !flag_ext);

  p_take_keeps_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_taken && irq_req && irq_vec == EXT_VEC && flag_pc) |=> flag_pc);

endmodule

bind ext_irq_ctrl irq_ctrl_chk #(
  .AW(AW), .DW(DW), .VEC_W(VEC_W), .FLAG_ADDR(FLAG_ADDR), .EXT_VEC(EXT_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .irq_req(irq_req), .irq_vec(irq_vec),
  .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .vec_taken(vec_taken), .flag_ext(flag_ext),
  .flag_pc(flag_pc), .en_ext(en_ext), .ext_evt(ext_evt),
  .ext_level(ext_level), .pc_evt(pc_evt)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic [1:0] sense_mode;
  logic       gie;
  logic       xint_pin;
  logic [4:0] watch_pins;
  logic       vec_taken;
  logic       irq_req;
  logic [8:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .sense_mode(sense_mode),
    .gie(gie), .xint_pin(xint_pin), .watch_pins(watch_pins),
    .vec_taken(vec_taken), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  localparam logic [5:0] A_EN = 6'h3B;
  localparam logic [5:0] A_FL = 6'h3A;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk);
    vec_taken = 1'b1;
    @(negedge clk);
    vec_taken = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_EN, d); chk("R1 enable reg after reset", d, 8'h00);
    rd(A_FL, d); chk("R2 pending reg after reset", d, 8'h00);
    chk("R9 irq_req after reset", irq_req, 0);
    chk("R9 irq_vec after reset", irq_vec, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_EN, 8'hFF);
    rd(A_EN, d); chk("R1/R3 enable readback", d, 8'h60);
    rd(A_FL, d); chk("R2 pending untouched by enable write", d, 8'h00);
    rd(6'h10, d); chk("R3 unmapped address", d, 8'h00);
    wr(A_EN, 8'h00);
    rd(A_EN, d); chk("R1 enable cleared", d, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    sense_mode = 2'b10;
    xint_pin = 1'b0; settle();
    rd(A_FL, d); chk("R4 falling sense, falling edge", d, 8'h40);
    wr(A_FL, 8'h40);
    rd(A_FL, d); chk("R10 write one clears ext flag", d, 8'h00);
    xint_pin = 1'b1; settle();
    rd(A_FL, d); chk("R4 falling sense ignores rising", d, 8'h00);
    sense_mode = 2'b11;
    xint_pin = 1'b0; settle();
    rd(A_FL, d); chk("R4 rising sense ignores falling", d, 8'h00);
    xint_pin = 1'b1; settle();
    rd(A_FL, d); chk("R4 rising sense, rising edge", d, 8'h40);
    wr(A_FL, 8'h40);
  endtask

  task automatic t_any();
    logic [7:0] d;
    sense_mode = 2'b01;
    xint_pin = 1'b0; settle();
    rd(A_FL, d); chk("R5 any-change on falling", d, 8'h40);
    wr(A_FL, 8'h40);
    xint_pin = 1'b1; settle();
    rd(A_FL, d); chk("R5 any-change on rising", d, 8'h40);
    wr(A_FL, 8'h40);
    sense_mode = 2'b10;
  endtask

  task automatic t_write_zero();
    logic [7:0] d;
    xint_pin = 1'b0; settle();
    wr(A_FL, 8'h00);
    rd(A_FL, d); chk("R10 writing zero keeps flag", d, 8'h40);
    wr(A_FL, 8'h9F);
    rd(A_FL, d); chk("R10 other ones keep ext flag", d, 8'h40);
    wr(A_FL, 8'h40);
    xint_pin = 1'b1; settle();
    rd(A_FL, d); chk("R10 cleared and no new flag", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    sense_mode = 2'b00;
    wr(A_EN, 8'h40);
    gie = 1'b1;
    settle();
    chk("R6 pin high, no request", irq_req, 0);
    xint_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 level low requests", irq_req, 1);
    chk("R6 level vector", irq_vec, 9'h001);
    rd(A_FL, d); chk("R6 no flag latched", d, 8'h00);
    xint_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 request drops on high", irq_req, 0);
    gie = 1'b0;
    wr(A_EN, 8'h00);
    sense_mode = 2'b10;
    settle();
  endtask

  task automatic t_pins();
    logic [7:0] d;
    watch_pins = 5'b00001; settle();
    rd(A_FL, d); chk("R7 low pin toggle", d, 8'h20);
    wr(A_FL, 8'h20);
    watch_pins = 5'b10001; settle();
    rd(A_FL, d); chk("R7 high pin toggle", d, 8'h20);
    watch_pins = 5'b00000; settle();
    rd(A_FL, d); chk("R7 flag holds over toggles", d, 8'h20);
    wr(A_FL, 8'h20);
    rd(A_FL, d); chk("R10 write one clears pc flag", d, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    watch_pins = 5'b00001; settle();
    rd(A_FL, d); chk("R8 flag set while disabled", d, 8'h20);
    wr(A_EN, 8'h20);
    chk("R8 gie low blocks", irq_req, 0);
    gie = 1'b1;
    wr(A_EN, 8'h00);
    chk("R8 enable low blocks", irq_req, 0);
    wr(A_EN, 8'h20);
    chk("R8 enabled request", irq_req, 1);
    chk("R9 pc vector", irq_vec, 9'h002);
    gie = 1'b0;
    wr(A_FL, 8'h20);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    wr(A_EN, 8'h60);
    @(negedge clk);
    xint_pin = 1'b0; watch_pins = 5'b00000;
    settle();
    gie = 1'b1;
    @(negedge clk);
    chk("R9 both pending request", irq_req, 1);
    chk("R9 external wins", irq_vec, 9'h001);
    take();
    chk("R11 hand over to pc vector", irq_vec, 9'h002);
    rd(A_FL, d); chk("R11 only ext flag cleared", d, 8'h20);
    take();
    chk("R11 second take drops request", irq_req, 0);
    rd(A_FL, d); chk("R11 both flags clear", d, 8'h00);
    gie = 1'b0;
    xint_pin = 1'b1; settle();
    wr(A_EN, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    sense_mode = 2'b10; gie = 1'b0; xint_pin = 1'b1;
    watch_pins = '0; vec_taken = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_edges();
    t_any();
    t_write_zero();
    t_level();
    t_pins();
    t_gate();
    t_prio();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule